// File: doc/BRIEF.md
# Flash Page Program Buffer

This block collects the data bytes of one serial flash page-program frame and, when the frame closes cleanly, writes them into the flash array one byte at a time. A command decoder upstream does the serial shifting and opcode recognition. It hands this block four things: the start address once the three address bytes are in, each complete data byte, and a frame-end strobe that says whether the frame stopped on a byte boundary. With the address it also passes the protection state of the sector that holds the start address.

Bytes are stored in a one-page buffer at the offset formed from the low address bits, and that offset wraps inside the page. A per-byte valid mask records which offsets received data. When the frame ends, the block decides whether to commit. A committed page is scanned from offset zero upward. Each marked byte produces one write strobe on the array port and then a fixed dwell time. Busy is raised for the whole sequence. Every closed frame makes the block request a clear of the write-enable latch. An error flag records any byte that the array reports as failing its verify.

Top module: `pgm_page_buf`

## Requirements
- R1: After a synchronous reset with `rst_n` low, `busy_o`, `wel_clr_o`, `err_o` and `arr_we_o` are all 0.
- R2: The k-th data byte of a frame (counting from 0) is written to array address {page of start address, (start[PAGE_W-1:0] + k) mod 2^PAGE_W}. Data that runs past the end of the page therefore wraps back to offset 0 of the same page.
- R3: When more than 2^PAGE_W data bytes arrive, each offset keeps the last byte sent to it, so only the most recent 2^PAGE_W bytes are programmed.
- R4: Array locations in the page that received no data in the frame are never written, and they keep their previous contents.
- R5: A frame is aborted, with no array write and `busy_o` staying 0, when no address was loaded, when no data byte was received, or when `aligned_i` is 0 at frame end.
- R6: A frame whose start address was flagged protected (`prot_i` = 1 with `addr_load_i`) programs nothing.
- R7: A frame that ends while `wel_i` is 0 programs nothing.
- R8: For a committed frame, `busy_o` rises in the cycle after the frame-end cycle. It stays high for exactly 2^PAGE_W + n*(PROG_CYCLES-1) cycles, where n is the number of distinct offsets written. Two write strobes are never adjacent.
- R9: `wel_clr_o` is a one-cycle pulse in the cycle after every frame end accepted while idle, whatever the outcome. For a committed frame it coincides with the rise of `busy_o`.
- R10: `err_o` becomes 1 in the cycle after a write strobe during which `arr_fail_i` is 1. It holds until the next committed frame starts, where it clears, and aborted frames leave it unchanged.
- R11: While `busy_o` is 1, `addr_load_i`, `byte_vld_i` and `frame_end_i` are ignored. They change neither the bytes being programmed nor the busy time, and they produce no `wel_clr_o` pulse.
- R12: Write strobes occur only while `busy_o` is 1, and within one commit the addresses they carry strictly ascend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load_i | input | 1 | Start address of the frame is complete |
| addr_i | input | ADDR_W | Start address |
| prot_i | input | 1 | Sector holding the start address is protected (sampled with addr_load_i) |
| byte_vld_i | input | 1 | One complete data byte is present |
| byte_i | input | DATA_W | Data byte |
| frame_end_i | input | 1 | Chip-select deassertion of the frame |
| aligned_i | input | 1 | Frame ended on a byte boundary (valid with frame_end_i) |
| wel_i | input | 1 | Current state of the write-enable latch |
| arr_fail_i | input | 1 | Array reports that the byte on the write port failed its verify |
| busy_o | output | 1 | Self-timed program sequence in progress |
| wel_clr_o | output | 1 | One-cycle request to clear the write-enable latch |
| err_o | output | 1 | A byte failed to verify during the last committed program |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |

## Verification
Suppose the write offset counter is wrong, the valid mask is wrong, or a byte is lost from the buffer. Each of these shows up as a wrong array byte or a stray write once busy falls, that is, within 2^PAGE_W + n*(PROG_CYCLES-1) cycles of the frame end. The busy length itself reveals a mask with too many or too few marked offsets. A wrong commit decision appears one cycle after frame end, as busy rising when it should not or failing to rise. A dwell counter that is off by one stretches or shortens every write gap, and so the total busy count.

// File: rtl/pgm_pkg.sv
// Package: shared types for the page program buffer.
// Assumes: nothing beyond standard SystemVerilog.
package pgm_pkg;

    // Program sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SCAN  = 2'd1,
        SQ_DWELL = 2'd2
    } seq_st_t;

endpackage

// File: rtl/pgm_ingest.sv
// Module: pgm_ingest
// Stores incoming data bytes in a one-page buffer at the wrapping in-page
// offset and keeps a per-offset valid mask. An address load restarts the
// offset and empties the mask. A later byte to the same offset overwrites
// the earlier one.
// Assumes: accept_i is low while the program sequence runs, and an address
// load and a data byte never arrive in the same cycle (the load wins).
module pgm_ingest #(
    parameter int PAGE_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              addr_load_i,
    input  logic [PAGE_W-1:0] start_off_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic [PAGE_W-1:0] rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_mask_o
);

    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [PAGE_W-1:0]     wr_off_q;
    logic [PAGE_BYTES-1:0] mask_q;
    logic [DATA_W-1:0]     pbuf_q [PAGE_BYTES];
    logic                  load_ok;
    logic                  wr_ok;

    assign load_ok = accept_i && addr_load_i;
    assign wr_ok   = accept_i && byte_vld_i && !addr_load_i;

    // Purpose: track the wrapping write offset and the per-offset valid mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_off_q <= '0;
            mask_q   <= '0;
        end else if (load_ok) begin
            wr_off_q <= start_off_i;
            mask_q   <= '0;
        end else if (wr_ok) begin
            wr_off_q         <= wr_off_q + 1'b1;
            mask_q[wr_off_q] <= 1'b1;
        end
    end

    // Purpose: hold the data bytes of the page (contents need no reset)
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            pbuf_q[wr_off_q] <= byte_i;
        end
    end

    assign rd_data_o = pbuf_q[rd_idx_i];
    assign rd_mask_o = mask_q[rd_idx_i];

endmodule

// File: rtl/pgm_commit.sv
// Module: pgm_commit
// Tracks the frame state (address seen, byte seen, protection, page) and
// decides at frame end whether the page is committed. Every frame end
// accepted while idle raises a one-cycle write-enable clear request.
// Assumes: frame_end_i is a single-cycle strobe from the command decoder.
module pgm_commit #(
    parameter int PG_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept_i,
    input  logic            addr_load_i,
    input  logic            prot_i,
    input  logic [PG_W-1:0] page_i,
    input  logic            byte_vld_i,
    input  logic            frame_end_i,
    input  logic            aligned_i,
    input  logic            wel_i,
    output logic            go_o,
    output logic [PG_W-1:0] page_o,
    output logic            wel_clr_o
);

    logic addr_ok_q;
    logic have_q;
    logic prot_q;
    logic have_any;
    logic end_ok;

    assign end_ok   = accept_i && frame_end_i;
    assign have_any = have_q || (byte_vld_i && !addr_load_i);
    assign go_o     = end_ok && addr_ok_q && have_any && aligned_i
                      && !prot_q && wel_i;

    // Purpose: record what the current frame has delivered so far
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_ok_q <= 1'b0;
            have_q    <= 1'b0;
            prot_q    <= 1'b0;
            page_o    <= '0;
        end else if (end_ok) begin
            addr_ok_q <= 1'b0;
            have_q    <= 1'b0;
        end else if (accept_i && addr_load_i) begin
            addr_ok_q <= 1'b1;
            have_q    <= 1'b0;
            prot_q    <= prot_i;
            page_o    <= page_i;
        end else if (accept_i && byte_vld_i && addr_ok_q) begin
            have_q    <= 1'b1;
        end
    end

    // Purpose: pulse the write-enable clear request after each frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_clr_o <= 1'b0;
        end else begin
            wel_clr_o <= end_ok;
        end
    end

endmodule

// File: rtl/pgm_seq.sv
// Module: pgm_seq
// Self-timed program sequencer. It scans every page offset in ascending
// order. A marked offset gives one write strobe and then PROG_CYCLES-1
// dwell cycles; an unmarked offset costs one cycle. A verify failure
// reported in the strobe cycle sets the sticky error flag, which clears
// when the next commit starts.
// Assumes: PROG_CYCLES >= 2, and go_i arrives only while idle.
module pgm_seq
    import pgm_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int PAGE_W      = 8,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     go_i,
    input  logic [ADDR_W-PAGE_W-1:0] page_i,
    output logic [PAGE_W-1:0]        rd_idx_o,
    input  logic [DATA_W-1:0]        rd_data_i,
    input  logic                     rd_mask_i,
    input  logic                     arr_fail_i,
    output logic                     busy_o,
    output logic                     arr_we_o,
    output logic [ADDR_W-1:0]        arr_addr_o,
    output logic [DATA_W-1:0]        arr_data_o,
    output logic                     err_o
);

    localparam int PG_W  = ADDR_W - PAGE_W;
    localparam int CNT_W = $clog2(PROG_CYCLES);

    seq_st_t          st_q;
    logic [PAGE_W-1:0] idx_q;
    logic [PG_W-1:0]   page_q;
    logic [CNT_W-1:0]  cnt_q;

    // Purpose: walk the page, strobe marked bytes and time each byte program
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= SQ_IDLE;
            idx_q      <= '0;
            page_q     <= '0;
            cnt_q      <= '0;
            arr_we_o   <= 1'b0;
            arr_addr_o <= '0;
            arr_data_o <= '0;
            err_o      <= 1'b0;
        end else begin
            arr_we_o <= 1'b0;
            if (arr_we_o && arr_fail_i) begin
                err_o <= 1'b1;
            end
            case (st_q)
                SQ_IDLE: begin
                    if (go_i) begin
                        st_q   <= SQ_SCAN;
                        idx_q  <= '0;
                        page_q <= page_i;
                        err_o  <= 1'b0;
                    end
                end
                SQ_SCAN: begin
                    if (rd_mask_i) begin
                        arr_we_o   <= 1'b1;
                        arr_addr_o <= {page_q, idx_q};
                        arr_data_o <= rd_data_i;
                        cnt_q      <= CNT_W'(PROG_CYCLES - 1);
                        st_q       <= SQ_DWELL;
                    end else if (&idx_q) begin
                        st_q <= SQ_IDLE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                SQ_DWELL: begin
                    if (cnt_q == CNT_W'(1)) begin
                        if (&idx_q) begin
                            st_q <= SQ_IDLE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= SQ_SCAN;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    assign rd_idx_o = idx_q;
    assign busy_o   = (st_q != SQ_IDLE);

endmodule

// File: rtl/pgm_page_buf.sv
// Module: pgm_page_buf (top)
// Page program buffer. It gathers the data bytes of a frame into a
// one-page buffer, decides at frame end whether to commit, and then drives
// a self-timed byte-by-byte write sequence into the flash array.
// Assumes: a command decoder upstream supplies the address, bytes and frame
// end as single-cycle strobes, and an array model answers verify status in
// the same cycle as each write strobe.
module pgm_page_buf #(
    parameter int ADDR_W      = 20,
    parameter int PAGE_W      = 8,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              prot_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              frame_end_i,
    input  logic              aligned_i,
    input  logic              wel_i,
    input  logic              arr_fail_i,
    output logic              busy_o,
    output logic              wel_clr_o,
    output logic              err_o,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [DATA_W-1:0] arr_data_o
);

    localparam int PG_W = ADDR_W - PAGE_W;

    logic              accept;
    logic              go;
    logic [PG_W-1:0]   page;
    logic [PAGE_W-1:0] rd_idx;
    logic [DATA_W-1:0] rd_data;
    logic              rd_mask;

    assign accept = !busy_o;

    pgm_ingest #(
        .PAGE_W (PAGE_W),
        .DATA_W (DATA_W)
    ) i_ingest (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .addr_load_i (addr_load_i),
        .start_off_i (addr_i[PAGE_W-1:0]),
        .byte_vld_i  (byte_vld_i),
        .byte_i      (byte_i),
        .rd_idx_i    (rd_idx),
        .rd_data_o   (rd_data),
        .rd_mask_o   (rd_mask)
    );

    pgm_commit #(
        .PG_W (PG_W)
    ) i_commit (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .addr_load_i (addr_load_i),
        .prot_i      (prot_i),
        .page_i      (addr_i[ADDR_W-1:PAGE_W]),
        .byte_vld_i  (byte_vld_i),
        .frame_end_i (frame_end_i),
        .aligned_i   (aligned_i),
        .wel_i       (wel_i),
        .go_o        (go),
        .page_o      (page),
        .wel_clr_o   (wel_clr_o)
    );

    pgm_seq #(
        .ADDR_W      (ADDR_W),
        .PAGE_W      (PAGE_W),
        .DATA_W      (DATA_W),
        .PROG_CYCLES (PROG_CYCLES)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go),
        .page_i     (page),
        .rd_idx_o   (rd_idx),
        .rd_data_i  (rd_data),
        .rd_mask_i  (rd_mask),
        .arr_fail_i (arr_fail_i),
        .busy_o     (busy_o),
        .arr_we_o   (arr_we_o),
        .arr_addr_o (arr_addr_o),
        .arr_data_o (arr_data_o),
        .err_o      (err_o)
    );

endmodule

// File: rtl/pgm_page_buf_chk.sv
// Module: pgm_page_buf_chk
// Port-level protocol checks for pgm_page_buf, attached with bind.
// Assumes: PROG_CYCLES >= 2.
module pgm_page_buf_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              wel_clr_o,
    input logic              err_o,
    input logic              arr_we_o,
    input logic              arr_fail_i,
    input logic [ADDR_W-1:0] arr_addr_o,
    input logic [DATA_W-1:0] arr_data_o
);

    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> busy_o);                                   // R12

    AST_WE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |=> !arr_we_o);                                // R8

    AST_START_WITH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> wel_clr_o);                           // R9

    AST_FAIL_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we_o && arr_fail_i) |=> err_o);                    // R10

    AST_ERR_CLR_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_o) |-> $rose(busy_o));                        // R10

    AST_NO_CLR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> !wel_clr_o);              // R11

endmodule

bind pgm_page_buf pgm_page_buf_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .wel_clr_o  (wel_clr_o),
    .err_o      (err_o),
    .arr_we_o   (arr_we_o),
    .arr_fail_i (arr_fail_i),
    .arr_addr_o (arr_addr_o),
    .arr_data_o (arr_data_o)
);

// File: tb/test_pgm_page_buf.sv
module test_pgm_page_buf;

    localparam int CLK_NS  = 10;
    localparam int ADDR_W  = 12;
    localparam int PAGE_W  = 8;
    localparam int DATA_W  = 8;
    localparam int PROG    = 3;
    localparam int MEM_SZ  = 1 << ADDR_W;
    localparam int PG_SZ   = 1 << PAGE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              addr_load_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic              prot_i = 1'b0;
    logic              byte_vld_i = 1'b0;
    logic [DATA_W-1:0] byte_i = '0;
    logic              frame_end_i = 1'b0;
    logic              aligned_i = 1'b0;
    logic              wel_i = 1'b0;
    logic              arr_fail_i;
    logic              busy_o, wel_clr_o, err_o, arr_we_o;
    logic [ADDR_W-1:0] arr_addr_o;
    logic [DATA_W-1:0] arr_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int fail_addr = -1;
    bit exp_err = 0;
    logic [7:0] mem [MEM_SZ];
    logic [7:0] exp_mem [MEM_SZ];
    int ord_bad = 0;
    bit have_prev = 0;
    logic [ADDR_W-1:0] prev_addr = '0;

    pgm_page_buf #(
        .ADDR_W (ADDR_W), .PAGE_W (PAGE_W), .DATA_W (DATA_W), .PROG_CYCLES (PROG)
    ) i_pgm_page_buf (
        .clk (clk), .rst_n (rst_n), .addr_load_i (addr_load_i), .addr_i (addr_i),
        .prot_i (prot_i), .byte_vld_i (byte_vld_i), .byte_i (byte_i),
        .frame_end_i (frame_end_i), .aligned_i (aligned_i), .wel_i (wel_i),
        .arr_fail_i (arr_fail_i), .busy_o (busy_o), .wel_clr_o (wel_clr_o),
        .err_o (err_o), .arr_we_o (arr_we_o), .arr_addr_o (arr_addr_o),
        .arr_data_o (arr_data_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [7:0] init_val(int a);
        return 8'((a * 37 + 5) ^ (a >> 3));
    endfunction

    function automatic int exp_busy(int n);
        return PG_SZ + n * (PROG - 1);
    endfunction

    // Behavioural array with verify-failure injection
    assign arr_fail_i = arr_we_o && (int'(arr_addr_o) == fail_addr);
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < MEM_SZ; a++) mem[a] <= init_val(a);
        end else if (arr_we_o) begin
            mem[arr_addr_o] <= arr_data_o;
        end
    end

    // Order monitor for R12
    always @(posedge clk) begin
        if (!busy_o) begin
            have_prev <= 1'b0;
        end else if (arr_we_o) begin
            if (have_prev && arr_addr_o <= prev_addr) ord_bad <= ord_bad + 1;
            have_prev <= 1'b1;
            prev_addr <= arr_addr_o;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_frame(int start, int n, bit do_addr, bit aligned, bit prot,
                             bit wel, bit junk, string req);
        logic [7:0] eb [PG_SZ];
        bit em [PG_SZ];
        bit acc;
        int distinct;
        int dur;
        int mism;
        int ord0;
        bit hit;
        int pg;
        for (int i = 0; i < PG_SZ; i++) em[i] = 0;
        acc = do_addr && (n > 0) && aligned && !prot && wel;
        pg  = start & ~(PG_SZ - 1);
        ord0 = ord_bad;
        if (do_addr) begin
            addr_load_i = 1'b1; addr_i = ADDR_W'(start); prot_i = prot;
            @(negedge clk);
            addr_load_i = 1'b0; prot_i = 1'b0;
        end
        for (int k = 0; k < n; k++) begin
            int off;
            off = (start + k) & (PG_SZ - 1);
            byte_vld_i = 1'b1; byte_i = 8'($urandom);
            eb[off] = byte_i; em[off] = 1;
            @(negedge clk);
        end
        byte_vld_i = 1'b0;
        frame_end_i = 1'b1; aligned_i = aligned; wel_i = wel;
        @(negedge clk);
        frame_end_i = 1'b0; aligned_i = 1'b0;
        distinct = 0; hit = 0;
        if (acc) begin
            for (int i = 0; i < PG_SZ; i++) if (em[i]) begin
                distinct++;
                exp_mem[pg + i] = eb[i];
                if (pg + i == fail_addr) hit = 1;
            end
            exp_err = hit;
        end
        // R9: pulse the cycle after frame end; R8/R5: busy rises only on commit
        chk(wel_clr_o == 1'b1, "R9", {req, " wel_clr pulse"}, int'(wel_clr_o), 1);
        chk(busy_o == acc, req, "busy after frame end", int'(busy_o), int'(acc));
        dur = busy_o ? 1 : 0;
        @(negedge clk);
        chk(wel_clr_o == 1'b0, "R9", "wel_clr one cycle", int'(wel_clr_o), 0);
        while (busy_o && dur < 4000) begin
            dur++;
            if (junk) begin
                // R11: stimulus while busy must be ignored
                addr_load_i = (dur == 4); addr_i = ADDR_W'($urandom);
                byte_vld_i  = (dur == 5); byte_i = 8'($urandom);
                frame_end_i = (dur == 6); aligned_i = (dur == 6); wel_i = 1'b1;
                if (dur == 8)
                    chk(wel_clr_o == 1'b0, "R11", "no clr while busy", int'(wel_clr_o), 0);
            end
            @(negedge clk);
        end
        addr_load_i = 1'b0; byte_vld_i = 1'b0; frame_end_i = 1'b0; aligned_i = 1'b0;
        chk(dur == (acc ? exp_busy(distinct) : 0), "R8", {req, " busy length"},
            dur, acc ? exp_busy(distinct) : 0);
        @(negedge clk);
        mism = 0;
        for (int a = 0; a < MEM_SZ; a++) if (mem[a] !== exp_mem[a]) mism++;
        chk(mism == 0, req, "array mismatches (R2 R4)", mism, 0);
        chk(err_o == exp_err, "R10", {req, " error flag"}, int'(err_o), int'(exp_err));
        chk(ord_bad == ord0, "R12", "write order", ord_bad - ord0, 0);
    endtask

    initial begin
        #(CLK_NS * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int a = 0; a < MEM_SZ; a++) exp_mem[a] = init_val(a);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy_o == 0, "R1", "busy in reset", int'(busy_o), 0);
        chk(wel_clr_o == 0, "R1", "wel_clr in reset", int'(wel_clr_o), 0);
        chk(err_o == 0, "R1", "err in reset", int'(err_o), 0);
        chk(arr_we_o == 0, "R1", "we in reset", int'(arr_we_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_frame(12'h0FE, 3, 1, 1, 0, 1, 0, "R2");     // wrap FE, FF, 00
        run_frame(12'h200, 256, 1, 1, 0, 1, 0, "R2");   // full page
        run_frame(12'h310, 300, 1, 1, 0, 1, 0, "R3");   // last 256 kept
        run_frame(12'h140, 5, 1, 1, 0, 1, 0, "R4");     // partial page
        run_frame(12'h150, 4, 0, 1, 0, 1, 0, "R5");     // no address
        run_frame(12'h160, 0, 1, 1, 0, 1, 0, "R5");     // no data byte
        run_frame(12'h170, 4, 1, 0, 0, 1, 0, "R5");     // misaligned end
        run_frame(12'h180, 4, 1, 1, 1, 1, 0, "R6");     // protected
        run_frame(12'h190, 4, 1, 1, 0, 0, 0, "R7");     // latch not set
        fail_addr = 12'h0A2;
        run_frame(12'h0A0, 6, 1, 1, 0, 1, 0, "R10");    // verify failure
        run_frame(12'h1A0, 2, 1, 1, 1, 1, 0, "R10");    // abort keeps err
        fail_addr = -1;
        run_frame(12'h0C0, 2, 1, 1, 0, 1, 0, "R10");    // commit clears err
        run_frame(12'h2F0, 40, 1, 1, 0, 1, 1, "R11");   // junk during busy

        for (int t = 0; t < 24; t++) begin
            int st, n;
            bit da, al, pr, we;
            st = int'($urandom % MEM_SZ);
            n  = ($urandom % 4 == 0) ? int'($urandom % 320) : 1 + int'($urandom % 24);
            da = ($urandom % 20) != 0;
            al = ($urandom % 10) != 0;
            pr = ($urandom % 7) == 0;
            we = ($urandom % 10) != 0;
            fail_addr = (t % 5 == 0) ? st : -1;
            run_frame(st, n, da, al, pr, we, t[0], "R2");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule